// File: doc/BRIEF.md
# TDM PCM Receive Slot Extractor

This block receives a serial time-division-multiplexed PCM stream and hands out a separate sample for each receive channel. A bit clock, a frame sync and a serial data line arrive as signals that are already synchronous to the system clock. The block finds the falling edges of the bit clock, counts bits and slots from the frame sync, and puts each eight-bit slot together MSB first. Each channel is set up to take one slot. When that slot, or that pair of slots, has fully arrived, the channel updates its sample output and pulses a one-cycle valid strobe.

Software programs one 8-bit register per channel through a simple write port with a combinational read-back. The register holds an enable flag and a slot number. A further register holds a global linear-mode flag. In companded mode a sample is the single byte of the programmed slot, with zero extension. In linear mode a sample is sixteen bits: the programmed slot gives the upper byte and the slot after it gives the lower byte. All settings pass into the capture logic only at a frame sync.

Top module: `pcm_slot_rx`

## Requirements
- R1: After reset every register reads 00h. No valid strobe occurs before the first frame sync, and every sample output is 0.
- R2: Channel k (0..NUM_CH-1) has its register at address k, with bit 7 as the enable and bits 6..0 as the slot number. The linear-mode flag is bit 0 at address NUM_CH. A read returns the last value written, and unused bits read 0.
- R3: dr_i is sampled on each falling edge of bclk_i. If fsync_i is 1 at that edge, the bit is bit 7 of slot 0. Later bits count down to bit 0, and then the next slot starts. A valid strobe only occurs in the cycle after a falling edge is seen.
- R4: In companded mode, an enabled channel with slot s presents {8'h00, byte of slot s} with a strobe once per frame. A slot number at or above FRAME_SLOTS never matches.
- R5: A disabled channel never strobes, and its sample output keeps its value.
- R6: In linear mode, an enabled channel with slot s presents {byte of slot s, byte of slot s+1}. It gives one strobe, after the second byte.
- R7: In linear mode with s = FRAME_SLOTS-1, the low byte comes from slot 0 of the next frame.
- R8: A register write takes effect only at the next frame sync. Capture in the current frame keeps using the old setting.
- R9: Each valid strobe lasts exactly one system clock. Between strobes, the sample output holds its value.
- R10: Channels work independently. Several channels may select the same slot, and each of them receives that slot's byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address for write and read |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| bclk_i | input | 1 | Serial bit clock, synchronous to clk_i |
| fsync_i | input | 1 | Frame sync, sampled on bit clock falling edge |
| dr_i | input | 1 | Serial receive data |
| smp_o | output | NUM_CH*16 | Per-channel samples, channel k at bits [16k+15:16k] |
| smp_vld_o | output | NUM_CH | Per-channel one-cycle valid strobe |

## Verification
The hardest case to reach is a linear-mode sample whose low byte lies beyond the frame boundary. The channel must keep its high byte pending through a frame sync, and that same frame sync also reloads every channel's configuration. The stimulus reaches this case by programming the last slot and then sending two full frames back to back with different data seeds. The expected word then joins the last byte of the first frame with the first byte of the second. A second hard case is a register write that arrives partway through a frame. The bench forks a write during frame transmission, so that the write lands before the programmed slot. It then checks that the old setting still governs that frame and that the new setting governs the next one.

// File: rtl/pcm_rx_pkg.sv
`timescale 1ns/1ps
package pcm_rx_pkg;
  localparam int SLOT_W = 7;
  localparam int BYTE_W = 8;
  localparam int SMP_W  = 2 * BYTE_W;

  typedef struct packed {
    logic              en;
    logic [SLOT_W-1:0] slot;
  } ch_cfg_t;
endpackage

// File: rtl/pcm_rx_deser.sv
`timescale 1ns/1ps
module pcm_rx_deser
  import pcm_rx_pkg::*;
#(
  parameter int FRAME_SLOTS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_i,
  input  logic              fsync_i,
  input  logic              dr_i,
  output logic              frame_o,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [SLOT_W-1:0] slot_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_SLOTS - 1);

  logic              bclk_q;
  logic              sync_q;
  logic [2:0]        bit_q, bit_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [BYTE_W-2:0] sh_q;
  logic              fall;

  assign fall = bclk_q & ~bclk_i;

  always_comb begin
    if (fsync_i) begin
      bit_d  = '0;
      slot_d = '0;
    end else if (bit_q == 3'd7) begin
      bit_d  = '0;
      slot_d = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
    end else begin
      bit_d  = bit_q + 1'b1;
      slot_d = slot_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= 1'b0;
      sync_q <= 1'b0;
      bit_q  <= 3'd7;
      slot_q <= LAST_SLOT;
      sh_q   <= '0;
    end else begin
      bclk_q <= bclk_i;
      if (fall) begin
        bit_q  <= bit_d;
        slot_q <= slot_d;
        sh_q   <= {sh_q[BYTE_W-3:0], dr_i};
        sync_q <= sync_q | fsync_i;
      end
    end
  end

  assign frame_o    = fall & fsync_i;
  assign byte_vld_o = fall & (bit_d == 3'd7) & sync_q;
  assign byte_o     = {sh_q, dr_i};
  assign slot_o     = slot_d;
endmodule

// File: rtl/pcm_rx_regs.sv
`timescale 1ns/1ps
module pcm_rx_regs
  import pcm_rx_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     reg_wr_i,
  input  logic [ADDR_W-1:0]        reg_addr_i,
  input  logic [BYTE_W-1:0]        reg_wdata_i,
  output logic [BYTE_W-1:0]        reg_rdata_o,
  input  logic                     frame_i,
  output ch_cfg_t [NUM_CH-1:0]     act_cfg_o,
  output logic                     act_lin_o
);
  localparam logic [ADDR_W-1:0] LIN_ADDR = ADDR_W'(NUM_CH);

  ch_cfg_t [NUM_CH-1:0] cfg_q;
  logic                 lin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      lin_q     <= 1'b0;
      act_cfg_o <= '0;
      act_lin_o <= 1'b0;
    end else begin
      if (reg_wr_i) begin
        for (int c = 0; c < NUM_CH; c++)
          if (reg_addr_i == ADDR_W'(c)) cfg_q[c] <= reg_wdata_i;
        if (reg_addr_i == LIN_ADDR) lin_q <= reg_wdata_i[0];
      end
      // shadow copy only at frame start
      if (frame_i) begin
        act_cfg_o <= cfg_q;
        act_lin_o <= lin_q;
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (reg_addr_i == ADDR_W'(c)) reg_rdata_o = cfg_q[c];
    if (reg_addr_i == LIN_ADDR) reg_rdata_o = {7'b0, lin_q};
  end
endmodule

// File: rtl/pcm_rx_chan.sv
`timescale 1ns/1ps
module pcm_rx_chan
  import pcm_rx_pkg::*;
#(
  parameter int FRAME_SLOTS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ch_cfg_t           cfg_i,
  input  logic              lin_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [SMP_W-1:0]  smp_o,
  output logic              vld_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_SLOTS - 1);

  logic              pend_q;
  logic [SLOT_W-1:0] nxt_q;
  logic [BYTE_W-1:0] hi_q;
  logic              hit, lo_hit;
  logic [SLOT_W-1:0] nxt_d;

  assign hit    = byte_vld_i & cfg_i.en & (slot_i == cfg_i.slot);
  assign lo_hit = byte_vld_i & pend_q & (slot_i == nxt_q);
  assign nxt_d  = (cfg_i.slot == LAST_SLOT) ? '0 : cfg_i.slot + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      nxt_q  <= '0;
      hi_q   <= '0;
      smp_o  <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (lo_hit) begin
        smp_o  <= {hi_q, byte_i};
        vld_o  <= 1'b1;
        pend_q <= 1'b0;
      end
      if (hit) begin
        if (lin_i) begin
          hi_q   <= byte_i;
          nxt_q  <= nxt_d;
          pend_q <= 1'b1;
        end else begin
          smp_o <= {{BYTE_W{1'b0}}, byte_i};
          vld_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_slot_rx.sv
`timescale 1ns/1ps
module pcm_slot_rx
  import pcm_rx_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int FRAME_SLOTS = 32,
  parameter int ADDR_W      = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    reg_wr_i,
  input  logic [ADDR_W-1:0]       reg_addr_i,
  input  logic [7:0]              reg_wdata_i,
  output logic [7:0]              reg_rdata_o,
  input  logic                    bclk_i,
  input  logic                    fsync_i,
  input  logic                    dr_i,
  output logic [NUM_CH*16-1:0]    smp_o,
  output logic [NUM_CH-1:0]       smp_vld_o
);
  ch_cfg_t [NUM_CH-1:0] act_cfg;
  logic                 act_lin;
  logic                 frame;
  logic                 byte_vld;
  logic [BYTE_W-1:0]    rx_byte;
  logic [SLOT_W-1:0]    rx_slot;

  pcm_rx_deser #(.FRAME_SLOTS(FRAME_SLOTS)) deser_i (
    .clk_i, .rst_ni, .bclk_i, .fsync_i, .dr_i,
    .frame_o(frame), .byte_vld_o(byte_vld), .byte_o(rx_byte), .slot_o(rx_slot)
  );

  pcm_rx_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) regs_i (
    .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .frame_i(frame), .act_cfg_o(act_cfg), .act_lin_o(act_lin)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pcm_rx_chan #(.FRAME_SLOTS(FRAME_SLOTS)) chan_i (
      .clk_i, .rst_ni,
      .cfg_i(act_cfg[c]), .lin_i(act_lin),
      .byte_vld_i(byte_vld), .byte_i(rx_byte), .slot_i(rx_slot),
      .smp_o(smp_o[c*SMP_W +: SMP_W]), .vld_o(smp_vld_o[c])
    );
  end
endmodule

// File: rtl/pcm_slot_rx_chk.sv
`timescale 1ns/1ps
module pcm_slot_rx_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 reg_wr_i,
  input logic [ADDR_W-1:0]    reg_addr_i,
  input logic [7:0]           reg_wdata_i,
  input logic [7:0]           reg_rdata_o,
  input logic                 bclk_i,
  input logic                 fsync_i,
  input logic [NUM_CH*16-1:0] smp_o,
  input logic [NUM_CH-1:0]    smp_vld_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else if (fsync_i) seen_q <= 1'b1;
  end

  assert_no_vld_before_sync_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> smp_vld_o == '0);

  assert_wr_readback_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i < ADDR_W'(NUM_CH)) |=>
      (reg_addr_i != $past(reg_addr_i)) || (reg_rdata_o == $past(reg_wdata_i)));

  assert_vld_on_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_o != '0) |-> ($past(bclk_i, 2) && !$past(bclk_i)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      smp_vld_o[c] |=> !smp_vld_o[c]);
    assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !smp_vld_o[c] |-> $stable(smp_o[c*16 +: 16]));
  end
endmodule

bind pcm_slot_rx pcm_slot_rx_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/pcm_slot_rx_tb_top.sv
`timescale 1ns/1ps
module pcm_slot_rx_tb_top;
  localparam int NUM_CH = 4;
  localparam int FRAME_SLOTS = 32;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] LIN_ADDR = ADDR_W'(NUM_CH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic bclk = 1'b0, fsync = 1'b0, dr = 1'b0;
  logic [NUM_CH*16-1:0] smp;
  logic [NUM_CH-1:0] smp_vld;

  int checks = 0;
  int failures = 0;
  int cnt [NUM_CH];
  logic [15:0] last [NUM_CH];
  logic [15:0] prev_smp [NUM_CH];
  logic [NUM_CH-1:0] prev_vld;

  always #2.5 clk = ~clk;

  pcm_slot_rx #(.NUM_CH(NUM_CH), .FRAME_SLOTS(FRAME_SLOTS), .ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .bclk_i(bclk),
    .fsync_i(fsync), .dr_i(dr), .smp_o(smp), .smp_vld_o(smp_vld)
  );

  function automatic logic [7:0] pat(int seed, int s);
    return 8'(s * 37 + seed * 91 + 5);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: counts strobes, checks pulse width and hold (R9)
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin
        cnt[c] = 0; last[c] = '0; prev_smp[c] = smp[c*16 +: 16];
      end
      prev_vld = '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (smp_vld[c]) begin
          cnt[c]++;
          last[c] = smp[c*16 +: 16];
          if (prev_vld[c]) chk("R9 strobe width", 32'(2), 32'(1));
        end else if (smp[c*16 +: 16] !== prev_smp[c]) begin
          chk("R9 hold", 32'(smp[c*16 +: 16]), 32'(prev_smp[c]));
        end
        prev_smp[c] = smp[c*16 +: 16];
      end
      prev_vld = smp_vld;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bclk = 1'b0; fsync = 1'b0; dr = 1'b0; reg_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr_reg(logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic send_frame(int seed);
    for (int s = 0; s < FRAME_SLOTS; s++) begin
      for (int b = 7; b >= 0; b--) begin
        logic [7:0] v;
        v = pat(seed, s);
        @(negedge clk);
        dr = v[b]; fsync = (s == 0 && b == 7); bclk = 1'b1;
        repeat (2) @(negedge clk);
        bclk = 1'b0;
        @(negedge clk);
      end
    end
    @(negedge clk);
    fsync = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // vector: {lin, en, ch[1:0], slot[6:0], exp_cnt[1:0]}
  localparam int NV = 7;
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 1'b1, 2'd0, 7'd3,  2'd2},  // R4
    {1'b0, 1'b1, 2'd2, 7'd31, 2'd2},  // R4 last slot
    {1'b0, 1'b0, 2'd1, 7'd5,  2'd0},  // R5 disabled
    {1'b1, 1'b1, 2'd1, 7'd10, 2'd2},  // R6
    {1'b1, 1'b1, 2'd3, 7'd0,  2'd2},  // R6 slot 0
    {1'b1, 1'b1, 2'd0, 7'd31, 2'd1},  // R7 wrap
    {1'b0, 1'b1, 2'd3, 7'd40, 2'd0}   // R4 out of frame
  };

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog", 32'(0), 32'(1));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    for (int a = 0; a <= NUM_CH; a++) begin
      @(negedge clk); reg_addr = ADDR_W'(a); #1;
      chk("R1 reg reset", 32'(reg_rdata), 32'(0));
    end
    chk("R1 smp reset", 32'(smp == '0), 32'(1));

    // R1 no strobe before first frame sync, even with data streaming
    wr_reg(0, 8'h80);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); dr = i[0]; bclk = 1'b1;
      repeat (2) @(negedge clk); bclk = 1'b0; @(negedge clk);
    end
    chk("R1 no strobe before sync", 32'(cnt[0]), 32'(0));

    // R2 read-back
    wr_reg(2, 8'hA5);
    wr_reg(LIN_ADDR, 8'hFF);
    @(negedge clk); reg_addr = 2; #1;
    chk("R2 channel readback", 32'(reg_rdata), 32'h A5);
    @(negedge clk); reg_addr = LIN_ADDR; #1;
    chk("R2 linear readback", 32'(reg_rdata), 32'h01);

    // vector walk
    for (int v = 0; v < NV; v++) begin
      logic lin, en;
      logic [1:0] ch, ecnt;
      logic [6:0] sl;
      logic [15:0] ev;
      {lin, en, ch, sl, ecnt} = VEC[v];
      if (ecnt == 0) ev = '0;
      else if (!lin) ev = {8'h00, pat(2, sl)};
      else if (sl == 7'(FRAME_SLOTS - 1)) ev = {pat(1, sl), pat(2, 0)};
      else ev = {pat(2, sl), pat(2, sl + 1)};
      do_reset();
      wr_reg(ADDR_W'(ch), {en, sl});
      wr_reg(LIN_ADDR, {7'b0, lin});
      send_frame(1);
      send_frame(2);
      chk($sformatf("R4/R5/R6/R7 vec%0d count", v), 32'(cnt[ch]), 32'(ecnt));
      chk($sformatf("R4/R5/R6/R7 vec%0d value", v), 32'(last[ch]), 32'(ev));
      for (int c = 0; c < NUM_CH; c++)
        if (c != int'(ch)) chk($sformatf("R5 vec%0d idle ch%0d", v, c), 32'(cnt[c]), 32'(0));
    end

    // R8 mid-frame writes
    do_reset();
    wr_reg(1, {1'b1, 7'd12});
    fork
      send_frame(1);
      begin
        repeat (200) @(negedge clk);
        wr_reg(0, {1'b1, 7'd20});
        wr_reg(1, 8'h00);
      end
    join
    chk("R8 new setting deferred", 32'(cnt[0]), 32'(0));
    chk("R8 old setting kept", 32'(cnt[1]), 32'(1));
    chk("R8 old setting value", 32'(last[1]), 32'({8'h00, pat(1, 12)}));
    send_frame(2);
    chk("R8 new setting active", 32'(cnt[0]), 32'(1));
    chk("R8 new setting value", 32'(last[0]), 32'({8'h00, pat(2, 20)}));
    chk("R8 disable applied", 32'(cnt[1]), 32'(1));

    // R10 shared and distinct slots
    do_reset();
    wr_reg(0, {1'b1, 7'd7});
    wr_reg(1, {1'b1, 7'd7});
    wr_reg(2, {1'b1, 7'd8});
    send_frame(3);
    chk("R10 ch0", 32'(last[0]), 32'({8'h00, pat(3, 7)}));
    chk("R10 ch1", 32'(last[1]), 32'({8'h00, pat(3, 7)}));
    chk("R10 ch2", 32'(last[2]), 32'({8'h00, pat(3, 8)}));
    chk("R10 ch3 idle", 32'(cnt[3]), 32'(0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule